// File: doc/BRIEF.md
# Nibble-Bus I/O Target Responder

This block is the target side of a low-pin-count host bus that carries commands, addresses and data four bits per clock. It watches the framing strobe and the shared nibble lines, and claims only single-byte I/O reads and writes whose 16-bit address falls inside a power-of-two window. The window is set by the parameters `WIN_BASE` and `WIN_SPAN`. A claimed cycle is handed to a simple local register port. That port carries a local address, a one-clock read or write strobe, write data, and a read-data / ready / error return. The shared lines are modelled as a separate output nibble and output enable, which the pad logic turns into the tri-state driver.

While the local side has not answered, the block drives short-wait sync codes onto the bus. When the answer arrives it drives a ready or error code. For a read it then returns the byte, low nibble first. Every target-owned phase ends with one clock of all-ones before the block releases the lines. If no answer arrives within `WAIT_LIMIT` wait clocks, the block reports an error and ends the cycle itself.

Memory, DMA and firmware cycles, reserved encodings, addresses outside the window, and aborted cycles all leave the block silent.

Top module: `nib_io_target`

## Requirements
- R1: During and right after reset, `nib_oe`, `loc_rd` and `loc_wr` are low.
- R2: A cycle is claimed only when the start nibble is 0000 and the following type nibble is 0000 (I/O read) or 0010 (I/O write). Any other start or type nibble causes no drive and no strobe for the rest of that cycle.
- R3: The address arrives in four clocks, most significant nibble first. The cycle is claimed only when address bits [15:log2(WIN_SPAN)] equal the same bits of `WIN_BASE`. `loc_addr` presents the low log2(WIN_SPAN) address bits.
- R4: `loc_rd` pulses for exactly one clock, in the clock after the last address nibble. `loc_wr` pulses for exactly one clock, in the clock after the second data nibble. The two never coincide, and neither pulses while `nib_oe` is high.
- R5: After the two host turn-around clocks the block drives sync nibbles. It drives 0101 for each wait clock, then 0000 once `loc_ready` has been seen, or 1010 if `loc_err` was high with `loc_ready`. `loc_ready` counts from the strobe clock onward. Ready in the c-th clock after the strobe clock (c = 0 for the strobe clock) gives max(0, c-1) wait nibbles.
- R6: If `WAIT_LIMIT` wait nibbles have been driven without ready, the next sync nibble is 1010, and no read data follows.
- R7: Write data is taken low nibble first from the two clocks after the address and presented on `loc_wdata`. After a 0000 sync on a read, the byte from `loc_rdata` is driven low nibble first over two clocks.
- R8: The target phase ends with one driven clock of 1111, then `nib_oe` falls. `nib_oe` is never high during host-driven clocks.
- R9: `frame_n` low in any clock ends the current cycle, and `nib_oe` is low in the next clock. A start nibble of 1111 leaves the block idle.
- R10: When `frame_n` stays low for several clocks, only the last start nibble before `frame_n` rises decides whether the cycle is for this target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, active low |
| frame_n | input | 1 | Cycle framing strobe, active low |
| nib_in | input | 4 | Nibble lines as seen at the pads |
| nib_out | output | 4 | Nibble the target drives |
| nib_oe | output | 1 | Drive enable for `nib_out` |
| loc_addr | output | log2(WIN_SPAN) | Offset of the access inside the window |
| loc_wr | output | 1 | One-clock local write strobe |
| loc_wdata | output | 8 | Local write data |
| loc_rd | output | 1 | One-clock local read strobe |
| loc_rdata | input | 8 | Local read data, valid with `loc_ready` |
| loc_ready | input | 1 | Local side has completed the access |
| loc_err | input | 1 | Local access failed, valid with `loc_ready` |

## Verification
The bench builds the block with a 16-byte window at 0x0A40 and a `WAIT_LIMIT` of 3. This makes every window offset cheap to read and write, and lets a flip of each of the twelve upper address bits be shown to lose the claim. With the small limit, a sweep of the local answer delay covers zero waits, exact-limit ready and timeout within a few clocks each. The small encodings allow all sixteen start nibbles and all sixteen type nibbles to be driven, along with multi-clock starts and a mid-sync abort.

// File: rtl/nib_io_target_pkg.sv
package nib_io_target_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_ADDR,
        PH_WDATA,
        PH_HTURN,
        PH_SYNC,
        PH_RDATA,
        PH_TTURN
    } phase_e;

    localparam logic [3:0] NIB_START_TGT = 4'h0;
    localparam logic [3:0] NIB_TYPE_RD   = 4'h0;
    localparam logic [3:0] NIB_TYPE_WR   = 4'h2;
    localparam logic [3:0] NIB_SYNC_OK   = 4'h0;
    localparam logic [3:0] NIB_SYNC_WAIT = 4'h5;
    localparam logic [3:0] NIB_SYNC_ERR  = 4'hA;
    localparam logic [3:0] NIB_ONES      = 4'hF;

    typedef struct packed {
        phase_e      ph;
        logic [1:0]  cnt;
        logic        start_ok;
        logic        is_wr;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  rdata;
        logic        done;
        logic        err;
    } tgt_state_t;

endpackage

// File: rtl/nib_window_match.sv
module nib_window_match #(
    parameter logic [15:0] BASE   = 16'h0A40,
    parameter int          LOC_AW = 4
) (
    input  logic [15:0] addr,
    output logic        hit
);
    generate
        if (LOC_AW >= 16) begin : g_full
            logic unused_addr;
            assign unused_addr = ^addr;
            assign hit = 1'b1;
        end else begin : g_cmp
            assign hit = (addr[15:LOC_AW] == BASE[15:LOC_AW]);
        end
    endgenerate
endmodule

// File: rtl/nib_wait_timer.sv
module nib_wait_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM_V = TW'(LIMIT);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM_V);
endmodule

// File: rtl/nib_io_target.sv
module nib_io_target
    import nib_io_target_pkg::*;
#(
    parameter logic [15:0] WIN_BASE   = 16'h0A40,
    parameter int          WIN_SPAN   = 16,
    parameter int          WAIT_LIMIT = 8,
    localparam int         LOC_AW     = $clog2(WIN_SPAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        nib_in,
    output logic [3:0]        nib_out,
    output logic              nib_oe,
    output logic [LOC_AW-1:0] loc_addr,
    output logic              loc_wr,
    output logic [7:0]        loc_wdata,
    output logic              loc_rd,
    input  logic [7:0]        loc_rdata,
    input  logic              loc_ready,
    input  logic              loc_err
);
    tgt_state_t cur_q, cur_d;
    logic win_hit;
    logic tmr_clr, tmr_tick, tmr_expired;
    logic strobe_slot;

    nib_window_match #(.BASE(WIN_BASE), .LOC_AW(LOC_AW)) u_win (
        .addr (cur_q.addr),
        .hit  (win_hit)
    );

    nib_wait_timer #(.LIMIT(WAIT_LIMIT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .tick    (tmr_tick),
        .expired (tmr_expired)
    );

    assign tmr_clr  = (cur_q.ph != PH_SYNC);
    assign tmr_tick = (cur_q.ph == PH_SYNC) && !cur_q.done && !tmr_expired;

    // Next-state computation
    always_comb begin
        cur_d = cur_q;
        if (!frame_n) begin
            // Any framed clock restarts decoding; last nibble wins
            cur_d.ph       = PH_START;
            cur_d.start_ok = (nib_in == NIB_START_TGT);
        end else begin
            unique case (cur_q.ph)
                PH_IDLE: ;
                PH_START: begin
                    if (cur_q.start_ok && (nib_in == NIB_TYPE_RD || nib_in == NIB_TYPE_WR)) begin
                        cur_d.ph    = PH_ADDR;
                        cur_d.cnt   = 2'd0;
                        cur_d.is_wr = (nib_in == NIB_TYPE_WR);
                        cur_d.done  = 1'b0;
                        cur_d.err   = 1'b0;
                    end else begin
                        cur_d.ph = PH_IDLE;
                    end
                end
                PH_ADDR: begin
                    cur_d.addr = {cur_q.addr[11:0], nib_in};
                    cur_d.cnt  = cur_q.cnt + 2'd1;
                    if (cur_q.cnt == 2'd3) begin
                        cur_d.cnt = 2'd0;
                        cur_d.ph  = cur_q.is_wr ? PH_WDATA : PH_HTURN;
                    end
                end
                PH_WDATA: begin
                    if (!win_hit) begin
                        cur_d.ph = PH_IDLE;
                    end else begin
                        if (cur_q.cnt == 2'd0) cur_d.wdata[3:0] = nib_in;
                        else                   cur_d.wdata[7:4] = nib_in;
                        cur_d.cnt = cur_q.cnt + 2'd1;
                        if (cur_q.cnt == 2'd1) begin
                            cur_d.cnt = 2'd0;
                            cur_d.ph  = PH_HTURN;
                        end
                    end
                end
                PH_HTURN: begin
                    if (cur_q.cnt == 2'd0 && !win_hit) begin
                        cur_d.ph = PH_IDLE;
                    end else begin
                        if (!cur_q.done && loc_ready) begin
                            cur_d.done  = 1'b1;
                            cur_d.err   = loc_err;
                            cur_d.rdata = loc_rdata;
                        end
                        cur_d.cnt = cur_q.cnt + 2'd1;
                        if (cur_q.cnt == 2'd1) begin
                            cur_d.cnt = 2'd0;
                            cur_d.ph  = PH_SYNC;
                        end
                    end
                end
                PH_SYNC: begin
                    if (cur_q.done || tmr_expired) begin
                        cur_d.cnt = 2'd0;
                        cur_d.ph  = (cur_q.done && !cur_q.err && !cur_q.is_wr) ? PH_RDATA : PH_TTURN;
                    end else if (loc_ready) begin
                        cur_d.done  = 1'b1;
                        cur_d.err   = loc_err;
                        cur_d.rdata = loc_rdata;
                    end
                end
                PH_RDATA: begin
                    cur_d.cnt = cur_q.cnt + 2'd1;
                    if (cur_q.cnt == 2'd1) begin
                        cur_d.cnt = 2'd0;
                        cur_d.ph  = PH_TTURN;
                    end
                end
                PH_TTURN: begin
                    cur_d.cnt = cur_q.cnt + 2'd1;
                    if (cur_q.cnt == 2'd1) begin
                        cur_d.cnt = 2'd0;
                        cur_d.ph  = PH_IDLE;
                    end
                end
                default: cur_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{ph: PH_IDLE, cnt: 2'd0, start_ok: 1'b0, is_wr: 1'b0,
                       addr: 16'h0, wdata: 8'h0, rdata: 8'h0, done: 1'b0, err: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    // Moore outputs from the registered phase
    always_comb begin
        nib_oe  = 1'b0;
        nib_out = NIB_ONES;
        unique case (cur_q.ph)
            PH_SYNC: begin
                nib_oe = 1'b1;
                if (cur_q.done)       nib_out = cur_q.err ? NIB_SYNC_ERR : NIB_SYNC_OK;
                else if (tmr_expired) nib_out = NIB_SYNC_ERR;
                else                  nib_out = NIB_SYNC_WAIT;
            end
            PH_RDATA: begin
                nib_oe  = 1'b1;
                nib_out = cur_q.cnt[0] ? cur_q.rdata[7:4] : cur_q.rdata[3:0];
            end
            PH_TTURN: begin
                nib_oe  = !cur_q.cnt[0];
                nib_out = NIB_ONES;
            end
            default: ;
        endcase
    end

    assign strobe_slot = (cur_q.ph == PH_HTURN) && (cur_q.cnt == 2'd0) && win_hit;
    assign loc_rd      = strobe_slot && !cur_q.is_wr;
    assign loc_wr      = strobe_slot && cur_q.is_wr;
    assign loc_wdata   = cur_q.wdata;
    assign loc_addr    = cur_q.addr[LOC_AW-1:0];

endmodule

// File: rtl/nib_io_target_chk.sv
module nib_io_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic       nib_oe,
    input logic [3:0] nib_out,
    input logic       loc_rd,
    input logic       loc_wr
);
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_rd && loc_wr));

    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rd |=> !loc_rd);

    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wr |=> !loc_wr);

    p_strobe_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd || loc_wr) |-> !nib_oe);

    p_turn_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd || loc_wr) |=> !nib_oe);

    p_frame_drops_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !nib_oe);

    p_release_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(nib_oe) && $past(frame_n)) |-> ($past(nib_out) == 4'hF));
endmodule

bind nib_io_target nib_io_target_chk u_nib_io_target_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .nib_oe  (nib_oe),
    .nib_out (nib_out),
    .loc_rd  (loc_rd),
    .loc_wr  (loc_wr)
);

// File: tb/nib_io_target_bench.sv
module nib_io_target_bench;
    localparam logic [15:0] BASE = 16'h0A40;
    localparam int SPAN = 16;
    localparam int LIM  = 3;
    localparam int AW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1;
    logic [3:0] nib_in = 4'hF;
    logic [3:0] nib_out;
    logic nib_oe;
    logic [AW-1:0] loc_addr;
    logic loc_wr, loc_rd;
    logic [7:0] loc_wdata;
    logic [7:0] loc_rdata = 8'h00;
    logic loc_ready = 1'b0;
    logic loc_err = 1'b0;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    nib_io_target #(.WIN_BASE(BASE), .WIN_SPAN(SPAN), .WAIT_LIMIT(LIM)) u_nib_io_target (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_in(nib_in),
        .nib_out(nib_out), .nib_oe(nib_oe), .loc_addr(loc_addr), .loc_wr(loc_wr),
        .loc_wdata(loc_wdata), .loc_rd(loc_rd), .loc_rdata(loc_rdata),
        .loc_ready(loc_ready), .loc_err(loc_err)
    );

    // Local register model: answers m_dly clocks after the strobe clock
    logic [7:0] mem [SPAN];
    logic [7:0] ref_mem [SPAN];
    int  m_dly = 0;
    bit  m_err = 0;
    bit  m_act = 0;
    int  m_cd = 0;

    initial begin
        for (int i = 0; i < SPAN; i++) begin
            mem[i] = 8'(i * 29 + 7);
            ref_mem[i] = 8'(i * 29 + 7);
        end
    end

    always @(negedge clk) begin
        if (loc_wr) mem[loc_addr] = loc_wdata;
        if (loc_rd || loc_wr) begin
            m_act = 1;
            m_cd = 0;
        end
        loc_ready = 1'b0;
        loc_err = 1'b0;
        loc_rdata = 8'h00;
        if (m_act) begin
            if (m_cd == m_dly) begin
                loc_ready = 1'b1;
                loc_err = m_err;
                loc_rdata = mem[loc_addr];
                m_act = 0;
            end
            m_cd++;
        end
    end

    // Observations gathered by the clock task
    int g_oe = 0, g_rd = 0, g_wr = 0;
    logic [AW-1:0] g_addr;
    logic [7:0] g_wd;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // One bus clock: drive at the falling edge, sample the state left by the last rising edge
    task automatic tick(input logic f, input logic [3:0] n, output logic [3:0] o, output logic oe);
        @(negedge clk);
        o = nib_out;
        oe = nib_oe;
        g_oe += int'(nib_oe);
        g_rd += int'(loc_rd);
        g_wr += int'(loc_wr);
        if (loc_rd || loc_wr) begin
            g_addr = loc_addr;
            g_wd = loc_wdata;
        end
        frame_n = f;
        nib_in = n;
    endtask

    task automatic bus_txn(input int pre, input logic [3:0] st, input logic [3:0] ct,
                           input logic [15:0] a, input logic [7:0] wd, input int dly,
                           input bit em, input bit claim, input string req);
        logic [3:0] o;
        logic oe;
        int waits, exp_waits;
        bit tout, is_wr;
        logic [3:0] exp_code;
        logic [7:0] exp_rd;
        is_wr = (ct == 4'h2);
        m_dly = dly;
        m_err = em;
        g_oe = 0; g_rd = 0; g_wr = 0;
        if (pre >= 0) tick(1'b0, 4'(pre), o, oe);
        tick(1'b0, st, o, oe);
        tick(1'b1, ct, o, oe);
        for (int i = 3; i >= 0; i--) tick(1'b1, a[i*4 +: 4], o, oe);
        if (is_wr) begin
            tick(1'b1, wd[3:0], o, oe);
            tick(1'b1, wd[7:4], o, oe);
        end
        tick(1'b1, 4'hF, o, oe);
        tick(1'b1, 4'hF, o, oe);
        check(g_oe == 0, req, "R8 drive during host clocks", g_oe, 0);
        if (!claim) begin
            for (int i = 0; i < 12; i++) tick(1'b1, 4'hF, o, oe);
            check(g_oe == 0, req, "R2 R3 unclaimed cycle drove bus", g_oe, 0);
            check(g_rd + g_wr == 0, req, "R2 R3 unclaimed cycle strobed", g_rd + g_wr, 0);
            return;
        end
        exp_waits = (dly - 1 < 0) ? 0 : ((dly - 1 > LIM) ? LIM : dly - 1);
        tout = (dly - 1 > LIM);
        exp_code = (tout || em) ? 4'hA : 4'h0;
        waits = 0;
        for (int i = 0; i < 30; i++) begin
            tick(1'b1, 4'hF, o, oe);
            if (oe && o == 4'h5) waits++;
            else break;
        end
        check(waits == exp_waits, req, "R5 R6 wait nibble count", waits, exp_waits);
        check(oe && o == exp_code, req, "R5 R6 final sync code", {oe, o}, {1'b1, exp_code});
        if (!is_wr && exp_code == 4'h0) begin
            exp_rd = ref_mem[a[AW-1:0]];
            tick(1'b1, 4'hF, o, oe);
            check(oe && o == exp_rd[3:0], req, "R7 read data low nibble", {oe, o}, {1'b1, exp_rd[3:0]});
            tick(1'b1, 4'hF, o, oe);
            check(oe && o == exp_rd[7:4], req, "R7 read data high nibble", {oe, o}, {1'b1, exp_rd[7:4]});
        end
        tick(1'b1, 4'hF, o, oe);
        check(oe && o == 4'hF, req, "R8 closing ones clock", {oe, o}, 5'h1F);
        tick(1'b1, 4'hF, o, oe);
        check(!oe, req, "R8 release after ones", oe, 0);
        if (is_wr) begin
            check(g_wr == 1 && g_rd == 0, req, "R4 write strobe count", g_wr * 16 + g_rd, 16);
            check(g_wd == wd, req, "R7 loc_wdata", g_wd, wd);
            ref_mem[a[AW-1:0]] = wd;
        end else begin
            check(g_rd == 1 && g_wr == 0, req, "R4 read strobe count", g_rd * 16 + g_wr, 16);
        end
        check(g_addr == a[AW-1:0], req, "R3 loc_addr", g_addr, a[AW-1:0]);
        tick(1'b1, 4'hF, o, oe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [3:0] o;
        logic oe;
        int bad;
        repeat (3) @(negedge clk);
        check(!nib_oe && !loc_rd && !loc_wr, "R1", "outputs in reset", {nib_oe, loc_rd, loc_wr}, 0);
        rst_n = 1'b1;
        g_oe = 0; g_rd = 0; g_wr = 0;
        for (int i = 0; i < 3; i++) tick(1'b1, 4'hF, o, oe);
        check(g_oe == 0 && g_rd == 0 && g_wr == 0, "R1", "outputs after reset", g_oe + g_rd + g_wr, 0);

        // R3 R7: reads at every window offset with short delays
        for (int a = 0; a < SPAN; a++)
            bus_txn(-1, 4'h0, 4'h0, BASE + 16'(a), 8'h00, a % 3, 0, 1, "R3 R7 read sweep");
        // R4 R7: writes at every offset, then read back
        for (int a = 0; a < SPAN; a++)
            bus_txn(-1, 4'h0, 4'h2, BASE + 16'(a), 8'(a * 53 + 17), a % 4, 0, 1, "R4 R7 write sweep");
        for (int a = 0; a < SPAN; a++)
            bus_txn(-1, 4'h0, 4'h0, BASE + 16'(a), 8'h00, 1, 0, 1, "R7 readback");
        // R5 R6: answer-delay sweep through the limit and beyond
        for (int d = 0; d <= LIM + 3; d++) begin
            bus_txn(-1, 4'h0, 4'h0, BASE + 16'd5, 8'h00, d, 0, 1, "R5 R6 read delay");
            bus_txn(-1, 4'h0, 4'h2, BASE + 16'd9, 8'(d + 200), d, 0, 1, "R5 R6 write delay");
        end
        // R5: local error
        bus_txn(-1, 4'h0, 4'h0, BASE + 16'd3, 8'h00, 1, 1, 1, "R5 read error");
        bus_txn(-1, 4'h0, 4'h2, BASE + 16'd4, 8'h66, 2, 1, 1, "R5 write error");
        // R3: each upper address bit flipped leaves the window
        for (int k = AW; k < 16; k++)
            bus_txn(-1, 4'h0, 4'h0, BASE ^ (16'h1 << k), 8'h00, 0, 0, 0, "R3 outside window");
        bus_txn(-1, 4'h0, 4'h2, BASE ^ 16'h8000, 8'h12, 0, 0, 0, "R3 write outside window");
        // R2: every other type nibble, every other start nibble
        for (int t = 0; t < 16; t++)
            if (t != 0 && t != 2)
                bus_txn(-1, 4'h0, 4'(t), BASE, 8'h00, 0, 0, 0, "R2 cycle type");
        for (int s = 1; s < 16; s++)
            bus_txn(-1, 4'(s), 4'h0, BASE, 8'h00, 0, 0, 0, "R2 R9 start nibble");
        // R10: multi-clock start
        bus_txn(15, 4'h0, 4'h0, BASE + 16'd2, 8'h00, 0, 0, 1, "R10 last start claims");
        bus_txn(0, 4'h5, 4'h0, BASE + 16'd2, 8'h00, 0, 0, 0, "R10 last start rejects");

        // R9: abort during sync wait
        m_dly = 60;
        m_err = 0;
        tick(1'b0, 4'h0, o, oe);
        tick(1'b1, 4'h0, o, oe);
        for (int i = 3; i >= 0; i--) tick(1'b1, 4'(BASE[i*4 +: 4] + (i == 0 ? 1 : 0)), o, oe);
        tick(1'b1, 4'hF, o, oe);
        tick(1'b1, 4'hF, o, oe);
        tick(1'b1, 4'hF, o, oe);
        check(oe && o == 4'h5, "R9", "sync wait before abort", {oe, o}, 5'h15);
        tick(1'b0, 4'hF, o, oe);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            tick(1'b1, 4'hF, o, oe);
            bad += int'(oe);
        end
        check(bad == 0, "R9", "drive after abort", bad, 0);
        bus_txn(-1, 4'h0, 4'h0, BASE + 16'd7, 8'h00, 0, 0, 1, "R9 recovery after abort");

        summary();
    end
endmodule